// File: doc/BRIEF.md
# Asynchronous SRAM Bridge

This block connects a synchronous request/response port to an external 32K x 8 asynchronous static RAM. A request carries a 15-bit address, a write flag and a write byte, and is taken on a valid/ready handshake. A read is answered with a one-cycle response pulse that carries the byte. The bridge drives the memory's active-low chip enable, output enable and write enable. It also drives the data bus as a split tri-state port: an output byte, a drive enable and an input byte, with the pad sitting outside the block.

Every timing rule the memory imposes is given as a nanosecond parameter. Each phase length in cycles is ceil(ns / CLK_PERIOD_NS), with a minimum of one cycle. Writes are controlled by write enable, with chip enable held low. Before the bridge drives the bus it always waits out the window in which the memory may still be driving it. An idle input lets chip enable rise between transactions to put the memory in standby. The next access after standby first waits out the power-up time.

Top module: `sram_bridge`

## Requirements
- R1: While reset is high and in the cycle after it is released, chip enable, output enable and write enable are all high, the bus drive enable is low, ready is high and response valid is low.
- R2: A read accepted with chip enable already low raises response valid exactly 1 + (ceil(70 ns / period) + 1) cycles after the accepting edge. A read from standby takes ceil(70 ns / period) more cycles. The returned byte is the byte last written to that address, or 0x00 if the address was never written.
- R3: At each rise of write enable: write enable has been low for at least 60 ns, the address has been stable for at least 60 ns, and the bus has been driven with the write byte for at least 30 ns.
- R4: The bridge never drives the bus while output enable is low. It starts driving no sooner than 25 ns after write enable falls. It stops driving one cycle after write enable rises.
- R5: The bus is never driven within 25 ns after output enable or chip enable rises.
- R6: The address does not change while write enable is low, and output enable and write enable are never low at the same time.
- R7: With the idle input high and no request, chip enable rises on the next cycle. With it low, chip enable stays low between transactions. Output enable or write enable falls no sooner than 70 ns after chip enable falls.
- R8: Ready is high only between transactions. It drops in the cycle after a request is accepted. Response valid lasts exactly one cycle, and only reads produce one.
- R9: While chip enable is low, successive address changes are at least 70 ns apart.
- R10: While chip enable is high, the bus is not driven and output enable and write enable are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_req | input | 1 | Allow standby (chip enable high) between transactions |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 15 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | 8 | Bus value when driven |
| mem_dq_oe | output | 1 | Bus drive enable (1 = drive) |
| mem_dq_i | input | 8 | Bus value seen at the pad |

## Verification
A phase counter that is off by one shows up at two places. The response strobe moves by a cycle on the next read. The memory model flags a short write pulse, setup or turnaround at the very strobe edge where it happens. A state machine that skips the float wait, or leaves output enable low into a write, is caught at the first sample taken after the bus drive enable rises. A wrong standby flag changes the read latency from standby by exactly the power-up cycle count. A state machine that never returns to idle holds ready low, so the next request stalls and the watchdog ends the run.

// File: rtl/sram_bridge_pkg.sv
`timescale 1ns/1ps
package sram_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_SETUP,
        ST_READ,
        ST_RECOVER,
        ST_WE_FLOAT,
        ST_WE_DRIVE,
        ST_WE_HOLD
    } bridge_state_e;

    // cycles needed to cover a nanosecond requirement, never fewer than one
    function automatic int phase_cycles(input int ns, input int period);
        int n;
        n = (ns + period - 1) / period;
        if (n < 1) n = 1;
        return n;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_bridge_fsm.sv
`timescale 1ns/1ps
module sram_bridge_fsm
    import sram_bridge_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4,
    parameter int N_PU   = 7,
    parameter int N_RD   = 8,
    parameter int N_TA   = 3,
    parameter int N_WZ   = 3,
    parameter int N_DRV  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idle_req,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    input  logic              tmr_zero
);
    localparam logic [CNT_W-1:0] L_PU  = CNT_W'(N_PU - 1);
    localparam logic [CNT_W-1:0] L_RD  = CNT_W'(N_RD - 1);
    localparam logic [CNT_W-1:0] L_TA  = CNT_W'(N_TA - 1);
    localparam logic [CNT_W-1:0] L_WZ  = CNT_W'(N_WZ - 1);
    localparam logic [CNT_W-1:0] L_DRV = CNT_W'(N_DRV - 1);

    typedef struct packed {
        bridge_state_e     st;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
        logic              is_wr;
        logic              rsp_v;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t d, q;

    always_comb begin
        d        = q;
        d.rsp_v  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    d.is_wr = req_write;
                    if (q.ce_n) begin
                        d.ce_n   = 1'b0;
                        d.st     = ST_WAKE;
                        tmr_load = 1'b1;
                        tmr_val  = L_PU;
                    end else begin
                        d.st = ST_SETUP;
                    end
                end else if (idle_req) begin
                    d.ce_n = 1'b1;
                end
            end
            ST_WAKE: begin
                if (tmr_zero) d.st = ST_SETUP;
            end
            ST_SETUP: begin
                tmr_load = 1'b1;
                if (q.is_wr) begin
                    d.we_n  = 1'b0;
                    d.st    = ST_WE_FLOAT;
                    tmr_val = L_WZ;
                end else begin
                    d.oe_n  = 1'b0;
                    d.st    = ST_READ;
                    tmr_val = L_RD;
                end
            end
            ST_READ: begin
                if (tmr_zero) begin
                    d.rdata  = mem_dq_i;
                    d.rsp_v  = 1'b1;
                    d.oe_n   = 1'b1;
                    d.st     = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = L_TA;
                end
            end
            ST_RECOVER: begin
                if (tmr_zero) d.st = ST_IDLE;
            end
            ST_WE_FLOAT: begin
                if (tmr_zero) begin
                    d.dq_oe  = 1'b1;
                    d.st     = ST_WE_DRIVE;
                    tmr_load = 1'b1;
                    tmr_val  = L_DRV;
                end
            end
            ST_WE_DRIVE: begin
                if (tmr_zero) begin
                    d.we_n = 1'b1;
                    d.st   = ST_WE_HOLD;
                end
            end
            ST_WE_HOLD: begin
                d.dq_oe = 1'b0;
                d.st    = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st    <= ST_IDLE;
            q.ce_n  <= 1'b1;
            q.oe_n  <= 1'b1;
            q.we_n  <= 1'b1;
            q.dq_oe <= 1'b0;
            q.is_wr <= 1'b0;
            q.rsp_v <= 1'b0;
            q.addr  <= '0;
            q.wdata <= '0;
            q.rdata <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_valid = q.rsp_v;
    assign rsp_rdata = q.rdata;
    assign mem_addr  = q.addr;
    assign mem_ce_n  = q.ce_n;
    assign mem_oe_n  = q.oe_n;
    assign mem_we_n  = q.we_n;
    assign mem_dq_o  = q.wdata;
    assign mem_dq_oe = q.dq_oe;

    // R6: read and write strobes are never active together
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(!q.oe_n && !q.we_n));

    // R6: address frozen for the whole write pulse
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !q.we_n |-> $stable(q.addr));

    // R4: drive starts only after write enable has already been low
    p_float_first_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(q.dq_oe) |-> (!q.we_n && !$past(q.we_n)));

    // R4: driving only with output enable high, during the pulse or one cycle after
    p_drive_window_r4: assert property (@(posedge clk) disable iff (rst)
        q.dq_oe |-> (q.oe_n && (!q.we_n || !$past(q.we_n))));

    // R10: deselected means no strobes and a floating bus
    p_deselect_float_r10: assert property (@(posedge clk) disable iff (rst)
        q.ce_n |-> (!q.dq_oe && q.oe_n && q.we_n));

    // R8: response strobe is a single cycle
    p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        q.rsp_v |=> !q.rsp_v);

    // R8: an accepted request makes the port busy
    p_accept_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/sram_bridge.sv
`timescale 1ns/1ps
module sram_bridge
    import sram_bridge_pkg::*;
#(
    parameter int ADDR_W          = 15,
    parameter int DATA_W          = 8,
    parameter int CLK_PERIOD_NS   = 10,
    parameter int T_CYCLE_NS      = 70,
    parameter int T_ADDR_ACC_NS   = 70,
    parameter int T_OE_ACC_NS     = 35,
    parameter int T_FLOAT_NS      = 25,
    parameter int T_WE_PULSE_NS   = 60,
    parameter int T_ADDR_SETUP_NS = 60,
    parameter int T_DATA_SETUP_NS = 30,
    parameter int T_WAKE_NS       = 70
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idle_req,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int C_CYC  = phase_cycles(T_CYCLE_NS, CLK_PERIOD_NS);
    localparam int N_PU   = phase_cycles(T_WAKE_NS, CLK_PERIOD_NS);
    // one spare cycle so capture lands strictly after data is valid
    localparam int N_RD   = max2(phase_cycles(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                                 phase_cycles(T_OE_ACC_NS, CLK_PERIOD_NS)) + 1;
    localparam int N_TA   = max2(phase_cycles(T_FLOAT_NS, CLK_PERIOD_NS), C_CYC - 1 - N_RD);
    localparam int N_WZ   = phase_cycles(T_FLOAT_NS, CLK_PERIOD_NS);
    localparam int N_DRV  = max2(phase_cycles(T_DATA_SETUP_NS, CLK_PERIOD_NS),
                            max2(phase_cycles(T_WE_PULSE_NS, CLK_PERIOD_NS) - N_WZ,
                            max2(phase_cycles(T_ADDR_SETUP_NS, CLK_PERIOD_NS) - 1 - N_WZ,
                                 C_CYC - 2 - N_WZ)));
    localparam int N_MAX  = max2(max2(N_PU, N_RD), max2(max2(N_TA, N_WZ), N_DRV));
    localparam int CNT_W  = $clog2(N_MAX + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_bridge_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .N_PU   (N_PU),
        .N_RD   (N_RD),
        .N_TA   (N_TA),
        .N_WZ   (N_WZ),
        .N_DRV  (N_DRV)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .idle_req  (idle_req),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .mem_dq_i  (mem_dq_i),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .tmr_zero  (tmr_zero)
    );

endmodule

// File: tb/test_sram_bridge.sv
`timescale 1ns/1ps
module test_sram_bridge;
    localparam int  PER      = 10;
    localparam int  T_PU     = 70;
    localparam int  T_FLT    = 25;
    localparam int  T_CYC    = 70;
    localparam int  RD_LAT   = 1 + ((70 + PER - 1) / PER) + 1;
    localparam int  PU_LAT   = (70 + PER - 1) / PER;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic idle_req = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [7:0] rsp_rdata;
    logic [14:0] mem_addr;
    logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0] mem_dq_o;
    logic [7:0] sram_q = 8'hEE;

    always #(PER/2) clk = ~clk;

    sram_bridge i_sram_bridge (
        .clk(clk), .rst(rst), .idle_req(idle_req),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(sram_q)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;
    logic [7:0] ref_mem [int];
    logic [7:0] sram [int];
    longint t_addr = -1000, t_ce_fall = -1000, t_oe_fall = -1000;
    longint t_we_fall = -1000, t_rel = -1000, t_dq = -1000;

    typedef struct { logic [7:0] data; int lat; int acc; } exp_t;
    exp_t q_exp[$];

    task automatic fail(input string r, input string what, input longint act, input longint exp);
        errors++;
        $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    endtask

    task automatic chk(input string r, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) fail(r, what, act, exp);
    endtask

    always @(posedge clk) cyc++;

    // ---------------- behavioural memory with timing checks ----------------
    always @(mem_addr) begin
        if (!rst) begin
            checks++;
            if (!mem_ce_n && !mem_we_n) fail("R6", "address moved during write pulse", 1, 0);
            if (!mem_ce_n && ($time - t_addr) < T_CYC) fail("R9", "address period ns", $time - t_addr, T_CYC);
        end
        t_addr = $time;
    end
    always @(negedge mem_ce_n) t_ce_fall = $time;
    always @(posedge mem_ce_n or posedge mem_oe_n) t_rel = $time;
    always @(negedge mem_oe_n) begin
        t_oe_fall = $time;
        if (!rst) begin
            checks++;
            if (($time - t_ce_fall) < T_PU) fail("R7", "read start after wake ns", $time - t_ce_fall, T_PU);
        end
    end
    always @(negedge mem_we_n) begin
        t_we_fall = $time;
        if (!rst) begin
            checks++;
            if (($time - t_ce_fall) < T_PU) fail("R7", "write start after wake ns", $time - t_ce_fall, T_PU);
        end
    end
    always @(posedge mem_dq_oe) t_dq = $time;
    always @(mem_dq_o) if (mem_dq_oe) t_dq = $time;
    always @(posedge mem_we_n) begin
        if (!rst && !mem_ce_n) begin
            checks++;
            if (($time - t_we_fall) < 60) fail("R3", "write pulse ns", $time - t_we_fall, 60);
            if (($time - t_addr) < 60) fail("R3", "address setup ns", $time - t_addr, 60);
            if (!mem_dq_oe) fail("R3", "bus driven at write end", 0, 1);
            else if (($time - t_dq) < 30) fail("R3", "data setup ns", $time - t_dq, 30);
            sram[int'(mem_addr)] = mem_dq_o;
        end
    end
    always @(negedge clk) begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n &&
            ($time - t_addr) >= 70 && ($time - t_oe_fall) >= 35 && ($time - t_ce_fall) >= 70)
            sram_q = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 8'h00;
        else
            sram_q = 8'hEE;
        if (!rst && mem_dq_oe) begin
            checks++;
            if (!mem_oe_n) fail("R4", "driving while output enable low", 0, 1);
            if (($time - t_rel) < T_FLT) fail("R5", "drive after release ns", $time - t_rel, T_FLT);
            if (!mem_we_n && ($time - t_we_fall) < T_FLT) fail("R4", "drive after write enable fall ns", $time - t_we_fall, T_FLT);
        end
    end

    // ---------------- response monitor ----------------
    logic rsp_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid && rsp_prev) fail("R8", "response pulse longer than one cycle", 2, 1);
            if (rsp_valid) begin
                if (q_exp.size() == 0) begin
                    fail("R8", "response without pending read", 1, 0);
                end else begin
                    exp_t e;
                    e = q_exp.pop_front();
                    chk("R2", "read byte", rsp_rdata, e.data);
                    chk("R2", "read latency", cyc - e.acc, e.lat);
                end
            end
        end
        rsp_prev = rsp_valid;
    end

    // ---------------- driver ----------------
    task automatic issue(input bit wr, input logic [14:0] a, input logic [7:0] dv, input bit cold);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dv;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8", "ready after accept", req_ready, 0);
        if (wr) begin
            ref_mem[int'(a)] = dv;
        end else begin
            e.data = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
            e.lat  = RD_LAT + (cold ? PU_LAT : 0);
            e.acc  = cyc;
            q_exp.push_back(e);
        end
    endtask

    task automatic settle(input int n);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_standby;
        settle(3);
        chk("R7", "chip enable high when idle allowed", mem_ce_n, 1);
        chk("R10", "no drive while deselected", mem_dq_oe, 0);
        chk("R10", "strobes high while deselected", {mem_oe_n, mem_we_n}, 2'b11);
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "chip enable in reset", mem_ce_n, 1);
        chk("R1", "output enable in reset", mem_oe_n, 1);
        chk("R1", "write enable in reset", mem_we_n, 1);
        chk("R1", "drive enable in reset", mem_dq_oe, 0);
        chk("R1", "ready in reset", req_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "chip enable after reset", mem_ce_n, 1);
        chk("R1", "response after reset", rsp_valid, 0);

        issue(1'b1, 15'h0000, 8'h3C, 1'b1);
        issue(1'b0, 15'h0000, 8'h00, 1'b0);
        issue(1'b1, 15'h7FFF, 8'hFF, 1'b0);
        issue(1'b0, 15'h7FFF, 8'h00, 1'b0);
        issue(1'b1, 15'h1234, 8'h00, 1'b0);
        issue(1'b0, 15'h1234, 8'h00, 1'b0);
        issue(1'b1, 15'h1234, 8'hA5, 1'b0);
        issue(1'b0, 15'h1234, 8'h00, 1'b0);
        issue(1'b0, 15'h0042, 8'h00, 1'b0);   // never written

        settle(4);
        chk("R7", "chip enable stays low without idle", mem_ce_n, 0);

        idle_req = 1'b1;
        check_standby();
        issue(1'b0, 15'h7FFF, 8'h00, 1'b1);
        check_standby();
        issue(1'b1, 15'h0055, 8'h96, 1'b1);
        check_standby();
        issue(1'b0, 15'h0055, 8'h00, 1'b1);
        idle_req = 1'b0;

        lfsr = 16'hACE1;
        for (int i = 0; i < 24; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            issue(lfsr[0], {12'h100, lfsr[3:1]}, lfsr[15:8], 1'b0);
        end

        settle(2);
        while (q_exp.size() != 0) @(negedge clk);
        chk("R8", "all reads answered", q_exp.size(), 0);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule